// File: doc/BRIEF.md
# I2C Target Controller with Host Register Handshake

This block is an I2C bus target (slave) that a host processor services through a four-entry register window. Both bus lines are sampled through a synchroniser with edge detection. From the synchronised lines the block recognises start and stop conditions and takes the first byte after each start as an address frame. If the upper seven bits of that frame equal the programmed own address, the block acknowledges it. A set direction bit moves the block into transmit mode without host action. A mismatched frame makes the block go silent until the next start.

Every data byte is handed over under software control. After each data byte the block raises an interrupt flag and holds SCL low, which is the only back-pressure the bus sees. It keeps SCL low until the host writes the data register (transmit) or reads it (receive). The host side carries no back-pressure: every register access completes in the cycle it is presented, and read data is valid combinationally in that same cycle. At the end of a read transfer, the master's NACK leaves the block holding SCL. The host then clears acknowledge-enable, clears the transmit-select bit and makes one dummy read of the data register to free the clock. The stop condition that follows raises the interrupt flag one last time.

Register window (reg_addr): 0 = data (read gives the last received byte, write supplies the next byte to send), 1 = control (bit0 transmit-select, bit1 acknowledge-enable, bit2 interrupt flag), 2 = status (bit0 captured acknowledge from the master, 1 = NACK), 3 = own address (bits 6:0).

Top module: `i2c_target_ctl`

## Requirements
- R1: After reset both bus drive outputs are 0 (released), control and status read 0, and the own-address register reads OWN_ADDR_RST (default 7'h2A) in bits 6:0 of offset 3; a write to offset 3 changes the address the block compares against.
- R2: A start (SDA falling while SCL is high) begins a new address frame and clears transmit-select. A stop (SDA rising while SCL is high) returns the block to idle and clears transmit-select. A stop also sets the interrupt flag (control bit2) only if the own address was matched since the last start, and a repeated start cancels that match.
- R3: When an address frame's bits 7:1 equal the own address, the block pulls SDA low during the ninth clock of that frame; with bit0 = 0 it then receives data bytes without raising the interrupt flag for the address.
- R4: When an address frame does not match, the block never drives SDA or SCL for the rest of that transfer, and the following stop leaves the interrupt flag at 0.
- R5: A matched address frame with bit0 = 1 sets transmit-select (control bit0) and the interrupt flag. SCL is held low after the ninth clock and stays low until the host writes the data register.
- R6: In transmit mode each byte written to the data register is sent MSB first. SDA changes only while SCL is low, and SDA is released during the ninth clock.
- R7: On the ninth clock of every transmitted byte, the level the master places on SDA is stored in status bit0 (0 = ACK, 1 = NACK). The block then sets the interrupt flag and holds SCL low until the next data-register write.
- R8: Writing 0 to control bit2 clears the interrupt flag and writing 1 leaves it unchanged. Writing 0 to control bit1 also clears status bit0.
- R9: While SCL is held after a transmitted byte and transmit-select is 0, a read of the data register releases SCL and the block takes no further part in the transfer; the next stop sets the interrupt flag.
- R10: In receive mode each data byte becomes readable at offset 0. The block acknowledges it (SDA low on the ninth clock) when control bit1 is 1 and leaves SDA high when it is 0. It then sets the interrupt flag and holds SCL low, with SDA released, until the host reads the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, well above the SCL rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | SCL level as seen on the bus |
| sda_in | input | 1 | SDA level as seen on the bus |
| scl_drive_low | output | 1 | 1 pulls SCL low (open-drain enable) |
| sda_drive_low | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_addr | input | 2 | Register offset of the host access |
| reg_wr | input | 1 | Host write strobe, one cycle per access |
| reg_rd | input | 1 | Host read strobe, one cycle per access |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Register contents at reg_addr, combinational |

## Verification
A wrong bit counter or shift register shows up inside a single byte. It gives a data-register value that does not equal what the master sent, a wrong bit on the serial read-back, or an acknowledge on the wrong clock, which the master sees as a missing ACK. A wrong stretch state is visible within a few block cycles of the ninth falling edge. It shows as SCL released before the host has serviced the byte, or as SCL never released, which stalls the master's next clock until the watchdog ends the run. Sweeping every foreign address and every byte value exposes a faulty compare or shift path on the first pattern that reaches it. A wrong flag path shows in the control or status read that follows each byte.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 7;
  localparam int RSEL_W  = 2;
  localparam int CNT_W   = $clog2(BYTE_W);

  localparam logic [RSEL_W-1:0] OFS_DATA = 2'd0;
  localparam logic [RSEL_W-1:0] OFS_CTRL = 2'd1;
  localparam logic [RSEL_W-1:0] OFS_STAT = 2'd2;
  localparam logic [RSEL_W-1:0] OFS_OWN  = 2'd3;

  localparam int CB_TXSEL = 0;
  localparam int CB_ACKEN = 1;
  localparam int CB_IRQ   = 2;

  typedef enum logic [2:0] {
    EG_IDLE, EG_RXBITS, EG_RXACK, EG_HOLDRX,
    EG_TXBITS, EG_TXACK, EG_HOLDTX, EG_SKIP
  } eng_state_t;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= 1'b1;
        else if (g == 0) chain[g] <= line_in;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b1;
    else prev <= chain[STAGES-1];
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_en,
  input  logic              tx_sel,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              data_wr,
  input  logic              data_rd,
  output logic              scl_hold,
  output logic              sda_low,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              set_irq,
  output logic              set_tx,
  output logic              clr_tx,
  output logic              ack_we,
  output logic              ack_val,
  output logic              stop_seen
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W-1);

  eng_state_t        state;
  logic [BYTE_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              full;
  logic              is_addr;
  logic              engaged;
  logic              start_c;
  logic              stop_c;

  assign start_c = scl_lvl & ~scl_rise & sda_fall;
  assign stop_c  = scl_lvl & ~scl_rise & sda_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= EG_IDLE; sh <= '0; cnt <= '0; full <= 1'b0;
      is_addr <= 1'b0; engaged <= 1'b0; scl_hold <= 1'b0;
      sda_low <= 1'b0; rx_byte <= '0; set_irq <= 1'b0;
      set_tx <= 1'b0; clr_tx <= 1'b0; ack_we <= 1'b0;
      ack_val <= 1'b0; stop_seen <= 1'b0;
    end else begin
      set_irq <= 1'b0; set_tx <= 1'b0; clr_tx <= 1'b0;
      ack_we <= 1'b0; stop_seen <= 1'b0;
      if (start_c) begin
        state <= EG_RXBITS; is_addr <= 1'b1; cnt <= '0; full <= 1'b0;
        sda_low <= 1'b0; scl_hold <= 1'b0; clr_tx <= 1'b1; engaged <= 1'b0;
      end else if (stop_c) begin
        state <= EG_IDLE; sda_low <= 1'b0; scl_hold <= 1'b0;
        clr_tx <= 1'b1; stop_seen <= 1'b1; set_irq <= engaged;
        engaged <= 1'b0;
      end else begin
        unique case (state)
          EG_RXBITS: begin
            if (scl_rise && !full) begin
              sh <= {sh[BYTE_W-2:0], sda_lvl};
              if (cnt == LAST_BIT) full <= 1'b1;
              else cnt <= cnt + 1'b1;
            end
            if (scl_fall && full) begin
              if (is_addr) begin
                if (sh[BYTE_W-1:1] == own_addr) begin
                  sda_low <= 1'b1; engaged <= 1'b1; state <= EG_RXACK;
                end else begin
                  state <= EG_SKIP;
                end
              end else begin
                sda_low <= ack_en; rx_byte <= sh; state <= EG_RXACK;
              end
            end
          end
          EG_RXACK: begin
            if (scl_fall) begin
              sda_low <= 1'b0; cnt <= '0; full <= 1'b0; is_addr <= 1'b0;
              if (is_addr && sh[0]) begin
                set_tx <= 1'b1; set_irq <= 1'b1; scl_hold <= 1'b1;
                state <= EG_HOLDTX;
              end else if (is_addr) begin
                state <= EG_RXBITS;
              end else begin
                set_irq <= 1'b1; scl_hold <= 1'b1; state <= EG_HOLDRX;
              end
            end
          end
          EG_HOLDRX: begin
            if (data_rd) begin
              scl_hold <= 1'b0; state <= EG_RXBITS;
            end
          end
          EG_HOLDTX: begin
            if (data_wr) begin
              sh <= tx_byte; sda_low <= ~tx_byte[BYTE_W-1]; cnt <= '0;
              scl_hold <= 1'b0; state <= EG_TXBITS;
            end else if (data_rd && !tx_sel) begin
              scl_hold <= 1'b0; state <= EG_SKIP;
            end
          end
          EG_TXBITS: begin
            if (scl_fall) begin
              if (cnt == LAST_BIT) begin
                sda_low <= 1'b0; state <= EG_TXACK;
              end else begin
                sh <= {sh[BYTE_W-2:0], 1'b0};
                sda_low <= ~sh[BYTE_W-2];
                cnt <= cnt + 1'b1;
              end
            end
          end
          EG_TXACK: begin
            if (scl_rise) begin
              ack_we <= 1'b1; ack_val <= sda_lvl;
            end
            if (scl_fall) begin
              set_irq <= 1'b1; scl_hold <= 1'b1; state <= EG_HOLDTX;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_target_ctl.sv
module i2c_target_ctl
  import i2ct_pkg::*;
#(
  parameter int                SYNC_STAGES  = 2,
  parameter logic [ADDR_W-1:0] OWN_ADDR_RST = 7'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  input  logic [RSEL_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata
);
  logic scl_lvl, scl_rise, scl_fall, sda_lvl, sda_rise, sda_fall;
  logic tx_sel_q, ack_en_q, irq_q, ack_cap_q;
  logic [ADDR_W-1:0] own_q;
  logic [BYTE_W-1:0] rx_byte;
  logic set_irq, set_tx, clr_tx, ack_we, ack_val, stop_seen;
  logic data_wr, data_rd, ctrl_wr, own_wr;

  i2ct_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .line_in(scl_in),
    .lvl(scl_lvl), .rise(scl_rise), .fall(scl_fall));

  i2ct_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .line_in(sda_in),
    .lvl(sda_lvl), .rise(sda_rise), .fall(sda_fall));

  assign data_wr = reg_wr && (reg_addr == OFS_DATA);
  assign data_rd = reg_rd && (reg_addr == OFS_DATA);
  assign ctrl_wr = reg_wr && (reg_addr == OFS_CTRL);
  assign own_wr  = reg_wr && (reg_addr == OFS_OWN);

  i2ct_engine u_engine (
    .clk(clk), .rst_n(rst_n),
    .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .own_addr(own_q), .ack_en(ack_en_q), .tx_sel(tx_sel_q),
    .tx_byte(reg_wdata), .data_wr(data_wr), .data_rd(data_rd),
    .scl_hold(scl_drive_low), .sda_low(sda_drive_low), .rx_byte(rx_byte),
    .set_irq(set_irq), .set_tx(set_tx), .clr_tx(clr_tx),
    .ack_we(ack_we), .ack_val(ack_val), .stop_seen(stop_seen));

  // Host writes first, engine events override them in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sel_q <= 1'b0; ack_en_q <= 1'b0; irq_q <= 1'b0;
      ack_cap_q <= 1'b0; own_q <= OWN_ADDR_RST;
    end else begin
      if (ctrl_wr) begin
        tx_sel_q <= reg_wdata[CB_TXSEL];
        ack_en_q <= reg_wdata[CB_ACKEN];
        if (!reg_wdata[CB_ACKEN]) ack_cap_q <= 1'b0;
        if (!reg_wdata[CB_IRQ]) irq_q <= 1'b0;
      end
      if (own_wr) own_q <= reg_wdata[ADDR_W-1:0];
      if (set_tx) tx_sel_q <= 1'b1;
      if (clr_tx) tx_sel_q <= 1'b0;
      if (set_irq) irq_q <= 1'b1;
      if (ack_we) ack_cap_q <= ack_val;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_DATA: reg_rdata = rx_byte;
      OFS_CTRL: begin
        reg_rdata[CB_TXSEL] = tx_sel_q;
        reg_rdata[CB_ACKEN] = ack_en_q;
        reg_rdata[CB_IRQ]   = irq_q;
      end
      OFS_STAT: reg_rdata[0] = ack_cap_q;
      default:  reg_rdata[ADDR_W-1:0] = own_q;
    endcase
  end
endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic scl_drive_low,
  input logic sda_drive_low,
  input logic irq_q,
  input logic tx_sel_q,
  input logic ack_en_q,
  input logic ack_cap_q,
  input logic stop_seen
);
  // R6: SDA drive only moves while the bus clock was low
  assert_sda_moves_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_drive_low != $past(sda_drive_low)) |-> !$past(scl_in));

  // R5 / R7 / R10: a new stretch is always announced by the flag
  assert_stretch_flags_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |=> irq_q);

  // R10: SDA is released whenever SCL is being stretched
  assert_no_sda_in_stretch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    scl_drive_low |-> !sda_drive_low);

  // R2: stop leaves transmit-select cleared
  assert_stop_clears_tx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !tx_sel_q);

  // R8: dropping acknowledge-enable wipes the captured acknowledge
  assert_acken_clears_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_en_q) |-> !ack_cap_q);
endmodule

bind i2c_target_ctl i2ct_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in),
  .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
  .irq_q(irq_q), .tx_sel_q(tx_sel_q), .ack_en_q(ack_en_q),
  .ack_cap_q(ack_cap_q), .stop_seen(stop_seen));

// File: tb/i2c_target_ctl_tb.sv
module i2c_target_ctl_tb;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic scl_line, sda_line, scl_drive_low, sda_drive_low;
  logic [1:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  int total = 0;
  int bad = 0;
  logic saw_sda = 1'b0;
  logic [6:0] own = 7'h2A;

  always #5 clk = ~clk;

  assign scl_line = m_scl & ~scl_drive_low;
  assign sda_line = m_sda & ~sda_drive_low;

  i2c_target_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  always @(posedge clk) if (sda_drive_low) saw_sda <= 1'b1;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rwrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rread(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1; d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic scl_up;
    m_scl = 1'b1;
    while (!scl_line) @(negedge clk);
    cyc(HALF);
  endtask

  task automatic scl_down;
    m_scl = 1'b0; cyc(HALF);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; cyc(HALF); scl_up; m_sda = 1'b0; cyc(HALF); scl_down;
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; cyc(HALF); scl_up; m_sda = 1'b1; cyc(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; cyc(HALF); scl_up; scl_down;
    end
    m_sda = 1'b1; cyc(HALF); scl_up; ack = sda_line; scl_down;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      cyc(HALF); scl_up; b[i] = sda_line; scl_down;
    end
    m_sda = ack; cyc(HALF); scl_up; scl_down; m_sda = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [7:0] b;
    logic ack;
    cyc(4); rst_n = 1'b1; cyc(2);

    // R1: reset state
    check(!scl_drive_low && !sda_drive_low, "R1 lines", {scl_drive_low, sda_drive_low}, 0);
    rread(2'd1, r); check(r == 8'h00, "R1 ctrl", r, 0);
    rread(2'd2, r); check(r == 8'h00, "R1 status", r, 0);
    rread(2'd3, r); check(r == 8'h2A, "R1 own", r, 8'h2A);
    own = 7'h51; rwrite(2'd3, {1'b0, own});
    rread(2'd3, r); check(r == {1'b0, own}, "R1 own write", r, {1'b0, own});
    rwrite(2'd1, 8'h02);

    // R4: every foreign address, both directions, is ignored
    for (int a = 0; a < 128; a++) begin
      if (a[6:0] == own) continue;
      saw_sda = 1'b0;
      bus_start; send_byte({a[6:0], a[0]}, ack); bus_stop; cyc(6);
      rread(2'd1, r);
      check(ack && !saw_sda && !r[2] && !scl_drive_low, "R4 foreign addr", {ack, saw_sda, r[2]}, 4);
    end

    // R3 / R10: write transfer with acknowledge-enable toggled per byte
    bus_start; send_byte({own, 1'b0}, ack);
    check(!ack, "R3 addr ack", ack, 0);
    cyc(4); rread(2'd1, r);
    check(r[2] == 1'b0 && r[0] == 1'b0, "R3 no irq on write addr", r, 8'h02);
    for (int k = 0; k < 40; k++) begin
      logic [7:0] d;
      logic en;
      d = 8'((k * 37 + 5) & 255);
      if (k == 0) d = 8'h00;
      if (k == 1) d = 8'hFF;
      en = (k % 3 != 2);
      rwrite(2'd1, {5'b0, 1'b1, en, 1'b0});
      send_byte(d, ack);
      check(ack == !en, "R10 ack per enable", ack, !en);
      cyc(4); rread(2'd1, r);
      check(r[2] && scl_drive_low && !sda_drive_low, "R10 irq+stretch", {r[2], scl_drive_low}, 3);
      rwrite(2'd1, {5'b0, 1'b0, en, 1'b0});
      rread(2'd1, r); check(!r[2], "R8 irq clear", r[2], 0);
      cyc(20); check(scl_drive_low, "R10 hold until read", scl_drive_low, 1);
      rread(2'd0, r); check(r == d, "R10 rx data", r, d);
      cyc(3); check(!scl_drive_low, "R10 release on read", scl_drive_low, 0);
    end
    rwrite(2'd1, 8'h03);
    bus_stop; cyc(6); rread(2'd1, r);
    check(r[2] == 1'b1 && r[0] == 1'b0, "R2 stop irq, tx cleared", r, 8'h06);
    rwrite(2'd1, 8'h06); rread(2'd1, r); check(r[2], "R8 write 1 keeps irq", r, 8'h06);
    rwrite(2'd1, 8'h02); rread(2'd1, r); check(r == 8'h02, "R8 write 0 clears irq", r, 8'h02);

    // R5-R9: read transfer over every byte value
    bus_start; send_byte({own, 1'b1}, ack);
    check(!ack, "R5 addr ack", ack, 0);
    cyc(50); rread(2'd1, r);
    check(r == 8'h07 && scl_drive_low && !scl_line, "R5 tx select+irq+stretch", r, 8'h07);
    for (int k = 0; k < 256; k++) begin
      logic last;
      last = (k == 255);
      rwrite(2'd1, 8'h03);
      rwrite(2'd0, 8'(k));
      recv_byte(last, b);
      check(b == 8'(k), "R6 msb-first byte", b, k);
      cyc(4); rread(2'd2, r);
      check(r[0] == last, "R7 captured ack", r[0], last);
      rread(2'd1, r);
      check(r[2] && scl_drive_low, "R7 irq+stretch after byte", {r[2], scl_drive_low}, 3);
    end
    rwrite(2'd1, 8'h01); rread(2'd2, r);
    check(r == 8'h00, "R8 acken clear wipes ack", r, 0);
    rwrite(2'd1, 8'h00); cyc(10);
    check(scl_drive_low, "R9 hold before dummy read", scl_drive_low, 1);
    rread(2'd0, r); cyc(3);
    check(!scl_drive_low && !sda_drive_low, "R9 dummy read releases", scl_drive_low, 0);
    bus_stop; cyc(6); rread(2'd1, r);
    check(r == 8'h04, "R9 stop irq", r, 8'h04);
    rwrite(2'd1, 8'h02);

    // R2: repeated start cancels a match; repeated start into read
    bus_start; send_byte({own, 1'b0}, ack);
    check(!ack, "R2 first addr ack", ack, 0);
    bus_start; send_byte({own ^ 7'h01, 1'b1}, ack);
    check(ack, "R2 rstart foreign no ack", ack, 1);
    bus_stop; cyc(6); rread(2'd1, r);
    check(!r[2], "R2 rstart cancels match", r, 8'h02);
    bus_start; send_byte({own, 1'b0}, ack);
    bus_start; send_byte({own, 1'b1}, ack);
    cyc(4); rread(2'd1, r);
    check(!ack && r[0] && r[2], "R2 rstart read match", r, 8'h07);
    rwrite(2'd1, 8'h02); rread(2'd0, r); cyc(3);
    check(!scl_drive_low, "R9 release without data", scl_drive_low, 0);
    bus_stop; cyc(6); rread(2'd1, r);
    check(r == 8'h06, "R2 stop after match", r, 8'h06);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule